// File: doc/BRIEF.md
# 8-bit ALU with status flags

This is a purely combinational arithmetic and logic unit for a small 8-bit processor datapath. One unit serves arithmetic, bitwise logic, signed comparison and address generation. A 4-bit operation select picks the function. The unit returns an 8-bit result together with zero, carry and overflow flags. A flag register is not part of the block, so the flags reflect the present inputs only.

The unit also widens a 6-bit signed immediate to 8 bits. That widened value is available as an output. When `use_imm` is high, it replaces the second operand, so immediate-form instructions and base-plus-offset address calculation use the same adder as register-form instructions.

Top module: `alu8_flags`

## Requirements
- R1: With `op_sel`=0 (add), `result` is (A+B) mod 256, `carry` is the carry out of bit 7, and `ovf` is 1 exactly when A and B have the same sign and the result's sign differs from it.
- R2: With `op_sel`=1 (subtract), `result` is (A−B) mod 256, `carry` is 1 when no borrow occurs (A ≥ B unsigned), and `ovf` is 1 exactly when A and B differ in sign and the result's sign differs from A's.
- R3: With `op_sel`=2 (AND), 3 (NAND) or 4 (OR), `result` is the bitwise function of A and B, and `carry` and `ovf` are both 0.
- R4: With `op_sel`=5 (set-less-than), `result` is 1 when A < B as signed two's complement and 0 otherwise, including when the subtraction would overflow. `carry` and `ovf` are 0.
- R5: With `op_sel`=6, `result` is A shifted left by one position with 0 entering bit 0. `carry` receives A[7], `ovf` is A[7] XOR A[6], and B is ignored.
- R6: With `op_sel`=7, `result` is A shifted right by one position with A[7] kept in bit 7. `carry` receives A[0], `ovf` is 0, and B is ignored.
- R7: With `op_sel`=8 (multiply), `result` is the low 8 bits of A×B, and `carry` and `ovf` are 0.
- R8: `zero` is 1 exactly when the 8-bit `result` is 0, for every operation.
- R9: `imm_ext` is the 6-bit `imm6` sign-extended to 8 bits: bits 5:0 equal `imm6`, and bits 7:6 copy `imm6[5]`.
- R10: When `use_imm` is 1, the second operand B is `imm_ext` and `op_b` has no effect. When `use_imm` is 0, B is `op_b`.
- R11: For `op_sel` codes 9 to 15, `result` is 0, `zero` is 1, and `carry` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | First operand A |
| op_b | input | 8 | Register second operand |
| imm6 | input | 6 | Signed immediate field |
| use_imm | input | 1 | Selects the widened immediate as operand B |
| op_sel | input | 4 | Operation select |
| result | output | 8 | Operation result |
| zero | output | 1 | Result is zero |
| carry | output | 1 | Carry, no-borrow, or shifted-out bit |
| ovf | output | 1 | Signed overflow |
| imm_ext | output | 8 | Sign-extended immediate |

## Verification
The embedded assertions check several algebraic relations whenever an input changes. Adding back the subtrahend must recover A, and subtracting the addend must recover A. Logic, compare and multiply operations must leave carry and overflow clear. The set-less-than result must be 0 or 1, the right shift must keep the sign bit, and the widened immediate must keep the numeric value of the 6-bit field. The bench scenarios are what show the actual values. These include the exact carry and overflow cases at the signed and unsigned boundaries, the compare across the overflow boundary, product truncation, reserved codes, and the fact that `op_b` is ignored when the immediate is selected.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W     = 8,
  parameter int IMM_W = 6
) (
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [IMM_W-1:0] imm6,
  input  logic             use_imm,
  input  logic [3:0]       op_sel,
  output logic [W-1:0]     result,
  output logic             zero,
  output logic             carry,
  output logic             ovf,
  output logic [W-1:0]     imm_ext
);
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_NAND = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_SLT  = 4'd5;
  localparam logic [3:0] OP_SHL  = 4'd6;
  localparam logic [3:0] OP_SRA  = 4'd7;
  localparam logic [3:0] OP_MUL  = 4'd8;
  localparam int         MSB     = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   sum_w, diff_w;
  logic [W-1:0] prod_lo;
  logic         add_v, sub_v, lt_s;

  assign imm_ext = {{(W-IMM_W){imm6[IMM_W-1]}}, imm6};
  assign b_eff   = use_imm ? imm_ext : op_b;

  assign sum_w   = {1'b0, op_a} + {1'b0, b_eff};
  assign diff_w  = {1'b0, op_a} + {1'b0, ~b_eff} + (W+1)'(1);
  assign prod_lo = op_a * b_eff;

  assign add_v = (op_a[MSB] == b_eff[MSB]) && (sum_w[MSB] != op_a[MSB]);
  assign sub_v = (op_a[MSB] != b_eff[MSB]) && (diff_w[MSB] != op_a[MSB]);
  assign lt_s  = diff_w[MSB] ^ sub_v;

  always_comb begin
    result = '0;
    carry  = 1'b0;
    ovf    = 1'b0;
    unique case (op_sel)
      OP_ADD:  begin result = sum_w[W-1:0];  carry = sum_w[W];  ovf = add_v; end
      OP_SUB:  begin result = diff_w[W-1:0]; carry = diff_w[W]; ovf = sub_v; end
      OP_AND:  result = op_a & b_eff;
      OP_NAND: result = ~(op_a & b_eff);
      OP_OR:   result = op_a | b_eff;
      OP_SLT:  result = {{(W-1){1'b0}}, lt_s};
      OP_SHL:  begin result = {op_a[W-2:0], 1'b0}; carry = op_a[MSB]; ovf = op_a[MSB] ^ op_a[MSB-1]; end
      OP_SRA:  begin result = {op_a[MSB], op_a[W-1:1]}; carry = op_a[0]; end
      OP_MUL:  result = prod_lo;
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);

  always_comb begin
    if (op_sel == OP_ADD) AST_ADD_INVERSE: assert (W'(result - b_eff) == op_a); // R1
    if (op_sel == OP_SUB) AST_SUB_INVERSE: assert (W'(result + b_eff) == op_a); // R2
    if (op_sel inside {OP_AND, OP_NAND, OP_OR}) AST_LOGIC_FLAGS: assert (!carry && !ovf); // R3
    if (op_sel == OP_SLT) AST_SLT_BOOL: assert (result[W-1:1] == '0 && !carry && !ovf); // R4
    if (op_sel == OP_SRA) AST_SRA_SIGN: assert (result[MSB] == op_a[MSB] && !ovf); // R6
    if (op_sel == OP_MUL) AST_MUL_FLAGS: assert (!carry && !ovf); // R7
    if (op_sel > OP_MUL) AST_RSVD_CODE: assert (zero && !carry && !ovf); // R11
    AST_IMM_VALUE: assert ($signed(imm_ext) == W'($signed(imm6))); // R9
  end
endmodule

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
  logic       clk = 1'b0;
  logic [7:0] op_a, op_b, result, imm_ext;
  logic [5:0] imm6;
  logic       use_imm, zero, carry, ovf;
  logic [3:0] op_sel;
  int n_run = 0, n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  alu8_flags u_dut (
    .op_a(op_a), .op_b(op_b), .imm6(imm6), .use_imm(use_imm), .op_sel(op_sel),
    .result(result), .zero(zero), .carry(carry), .ovf(ovf), .imm_ext(imm_ext)
  );

  // {op, A, B, result, zero, carry, ovf}
  localparam int NV = 23;
  localparam logic [30:0] VECS [NV] = '{
    {4'd0, 8'h10, 8'h20, 8'h30, 3'b000},  // R1
    {4'd0, 8'hFF, 8'h01, 8'h00, 3'b110},  // R1 R8
    {4'd0, 8'h7F, 8'h01, 8'h80, 3'b001},  // R1
    {4'd1, 8'h05, 8'h03, 8'h02, 3'b010},  // R2
    {4'd1, 8'h03, 8'h05, 8'hFE, 3'b000},  // R2
    {4'd1, 8'h80, 8'h01, 8'h7F, 3'b011},  // R2
    {4'd1, 8'h42, 8'h42, 8'h00, 3'b110},  // R2 R8
    {4'd2, 8'hF0, 8'h3C, 8'h30, 3'b000},  // R3
    {4'd3, 8'hFF, 8'hFF, 8'h00, 3'b100},  // R3
    {4'd3, 8'hF0, 8'h3C, 8'hCF, 3'b000},  // R3
    {4'd4, 8'h0A, 8'h50, 8'h5A, 3'b000},  // R3
    {4'd5, 8'hFE, 8'h01, 8'h01, 3'b000},  // R4
    {4'd5, 8'h01, 8'hFE, 8'h00, 3'b100},  // R4
    {4'd5, 8'h80, 8'h7F, 8'h01, 3'b000},  // R4
    {4'd5, 8'h05, 8'h05, 8'h00, 3'b100},  // R4
    {4'd6, 8'h81, 8'h77, 8'h02, 3'b011},  // R5
    {4'd6, 8'h21, 8'hFF, 8'h42, 3'b000},  // R5
    {4'd7, 8'h81, 8'h13, 8'hC0, 3'b010},  // R6
    {4'd7, 8'h01, 8'hFF, 8'h00, 3'b110},  // R6
    {4'd8, 8'h10, 8'h11, 8'h10, 3'b000},  // R7
    {4'd8, 8'h07, 8'h06, 8'h2A, 3'b000},  // R7
    {4'd8, 8'h10, 8'h10, 8'h00, 3'b100},  // R7
    {4'd15, 8'h55, 8'hAA, 8'h00, 3'b100}  // R11
  };

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic ui, input logic [5:0] im);
    @(posedge clk);
    op_sel = op; op_a = a; op_b = b; use_imm = ui; imm6 = im;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected <5000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    op_sel = 0; op_a = 0; op_b = 0; use_imm = 0; imm6 = 0;
    @(negedge clk);
    check("R8 idle inputs", {result, zero, carry, ovf}, {8'h00, 3'b100});

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][30:27], VECS[i][26:19], VECS[i][18:11], 1'b0, 6'h00);
      check($sformatf("vector %0d (R1..R11 table)", i),
            {result, zero, carry, ovf}, VECS[i][10:0]);
    end

    apply(4'd0, 8'h00, 8'h00, 1'b0, 6'h1F);
    check("R9 positive imm", {3'b0, imm_ext}, {3'b0, 8'h1F});
    apply(4'd0, 8'h00, 8'h00, 1'b0, 6'h20);
    check("R9 most negative imm", {3'b0, imm_ext}, {3'b0, 8'hE0});
    apply(4'd0, 8'h00, 8'h00, 1'b0, 6'h3F);
    check("R9 minus one", {3'b0, imm_ext}, {3'b0, 8'hFF});

    apply(4'd0, 8'h10, 8'h99, 1'b1, 6'h3F);
    check("R10 add imm -1", {result, zero, carry, ovf}, {8'h0F, 3'b010});
    apply(4'd0, 8'h10, 8'h01, 1'b1, 6'h3F);
    check("R10 op_b ignored", {result, zero, carry, ovf}, {8'h0F, 3'b010});
    apply(4'd1, 8'h05, 8'hEE, 1'b1, 6'h02);
    check("R10 sub imm", {result, zero, carry, ovf}, {8'h03, 3'b010});
    apply(4'd5, 8'hFD, 8'h00, 1'b1, 6'h3E);
    check("R4 R10 slt -3 < -2", {result, zero, carry, ovf}, {8'h01, 3'b000});
    apply(4'd9, 8'hFF, 8'hFF, 1'b0, 6'h00);
    check("R11 code 9", {result, zero, carry, ovf}, {8'h00, 3'b100});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule